// File: doc/BRIEF.md
# USB Host Frame Timing Counter

This block keeps the frame timebase of a full-speed USB host. A 14-bit down-counter tracks the bit times left in the current frame and steps once per bit-time strobe. After the count reaches zero, the next strobe reloads it from a programmable frame interval. That same strobe advances a 16-bit frame number and raises a start-of-frame pulse. Software writes the interval together with a toggle bit. The toggle is copied into the remaining-count word at each reload, so software can tell whether the running count came from the interval it last wrote.

The counters run only while `run` is high. The cycle in which `run` rises is the entry to the operational state. On that cycle the count and the toggle are loaded at once from the stored interval. While `run` is low, everything holds.

Top module: `usb_frame_timer`

## Requirements
- R1: After reset the remaining-count word and the frame number read 0, `sof` is low, the stored interval reads 11999 and the stored toggle reads 0.
- R2: `rem_word` carries the remaining count in bits 13:0 and the copied toggle in bit 31. Bits 30:14 always read 0.
- R3: While operating, each clock with `bit_stb` high and a nonzero count lowers the count by one. A clock without `bit_stb` leaves the count unchanged.
- R4: While operating, a `bit_stb` clock with the count at zero reloads the count from the stored interval and adds one to `fnum`. `sof` is high for exactly the cycle that follows that edge.
- R5: At each reload and at each entry load, bit 31 of `rem_word` takes the stored toggle.
- R6: On the first clock with `run` high after a clock with `run` low, the count and toggle are loaded from the stored interval. This happens whatever `bit_stb` is, and neither `fnum` nor `sof` changes on that clock.
- R7: While `run` is low, the count, toggle and `fnum` hold their values and `sof` stays low.
- R8: A clock with `ivl_wr` high updates only `ivl_val` and `ivl_tgl`. The running count and its toggle keep their values until the next reload or entry.
- R9: `fnum` wraps from 65535 to 0.
- R10: With the default interval, the first `sof` after entry follows exactly 12000 strobes, and a 1 ms frame spans 12000 bit times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_stb | input | 1 | One-cycle bit-time strobe |
| run | input | 1 | High while in the operational state |
| ivl_wr | input | 1 | Write strobe for the interval register |
| ivl_wr_val | input | 14 | Interval value to store |
| ivl_wr_tgl | input | 1 | Toggle bit stored with the interval |
| ivl_val | output | 14 | Stored interval read-back |
| ivl_tgl | output | 1 | Stored toggle read-back |
| rem_word | output | 32 | Remaining-count word: toggle at bit 31, count at bits 13:0 |
| fnum | output | 16 | Frame number |
| sof | output | 1 | Start-of-frame pulse |

## Verification
The bench builds the block with its default widths and the default interval of 11999. It times one complete 12000-strobe frame to check that value. It then programs intervals of 3, 5 and 2, which makes reload, toggle hand-over, mid-frame writes and re-entry visible within a few strobes. An interval of 0 turns every strobe into a frame, and that brings the 16-bit frame-number wrap within about 65000 cycles.

// File: rtl/usb_frame_timer.sv
module usb_frame_timer #(
  parameter int CNT_W        = 14,
  parameter int FN_W         = 16,
  parameter int WORD_W       = 32,
  parameter int DEF_INTERVAL = 11999
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_stb,
  input  logic              run,
  input  logic              ivl_wr,
  input  logic [CNT_W-1:0]  ivl_wr_val,
  input  logic              ivl_wr_tgl,
  output logic [CNT_W-1:0]  ivl_val,
  output logic              ivl_tgl,
  output logic [WORD_W-1:0] rem_word,
  output logic [FN_W-1:0]   fnum,
  output logic              sof
);
  localparam int PAD_W = WORD_W - 1 - CNT_W;

  logic [CNT_W-1:0] rem_cnt;
  logic             rem_tgl;
  logic             run_q;

  wire entry  = run & ~run_q;
  wire step   = run & run_q & bit_stb;
  wire reload = step & (rem_cnt == '0);

  assign rem_word = {rem_tgl, {PAD_W{1'b0}}, rem_cnt};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ivl_val <= CNT_W'(DEF_INTERVAL);
      ivl_tgl <= 1'b0;
    end else if (ivl_wr) begin
      ivl_val <= ivl_wr_val;
      ivl_tgl <= ivl_wr_tgl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_cnt <= '0;
      rem_tgl <= 1'b0;
      fnum    <= '0;
      sof     <= 1'b0;
      run_q   <= 1'b0;
    end else begin
      run_q <= run;
      sof   <= reload;
      if (entry || reload) begin
        rem_cnt <= ivl_val;
        rem_tgl <= ivl_tgl;
      end else if (step) begin
        rem_cnt <= rem_cnt - 1'b1;
      end
      if (reload) fnum <= fnum + 1'b1;
    end
  end
endmodule

module usb_frame_timer_chk #(
  parameter int CNT_W  = 14,
  parameter int FN_W   = 16,
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bit_stb,
  input logic              run,
  input logic [CNT_W-1:0]  ivl_val,
  input logic [WORD_W-1:0] rem_word,
  input logic [FN_W-1:0]   fnum,
  input logic              sof
);
  wire [CNT_W-1:0] cnt = rem_word[CNT_W-1:0];

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> ($stable(fnum) && !sof)); // R7
  AST_SOF_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    sof |-> (fnum == FN_W'($past(fnum) + 1'b1))); // R4
  AST_SOF_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    sof |-> (cnt == $past(ivl_val))); // R4
  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && bit_stb && cnt != '0) |=> (cnt == CNT_W'($past(cnt) - 1'b1))); // R3
  AST_NO_STROBE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && !bit_stb) |=> $stable(cnt)); // R3
  AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rem_word[WORD_W-2:CNT_W] == '0); // R2
endmodule

bind usb_frame_timer usb_frame_timer_chk #(.CNT_W(CNT_W), .FN_W(FN_W), .WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .run(run), .ivl_val(ivl_val),
  .rem_word(rem_word), .fnum(fnum), .sof(sof)
);

// File: tb/usb_frame_timer_tb.sv
module usb_frame_timer_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_stb = 1'b0, run = 1'b0, ivl_wr = 1'b0, ivl_wr_tgl = 1'b0;
  logic [13:0] ivl_wr_val = '0;
  logic [13:0] ivl_val;
  logic        ivl_tgl;
  logic [31:0] rem_word;
  logic [15:0] fnum;
  logic        sof;
  int n_chk = 0, n_fail = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  usb_frame_timer u_dut (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .run(run), .ivl_wr(ivl_wr),
    .ivl_wr_val(ivl_wr_val), .ivl_wr_tgl(ivl_wr_tgl), .ivl_val(ivl_val),
    .ivl_tgl(ivl_tgl), .rem_word(rem_word), .fnum(fnum), .sof(sof)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wr_ivl(input logic [13:0] v, input logic t);
    ivl_wr = 1'b1; ivl_wr_val = v; ivl_wr_tgl = t;
    tick();
    ivl_wr = 1'b0;
  endtask

  task automatic t_reset();
    chk(rem_word == 0, "R1 rem_word", rem_word, 0);
    chk(fnum == 0, "R1 fnum", fnum, 0);
    chk(!sof, "R1 sof", sof, 0);
    chk(ivl_val == 11999, "R1 ivl_val", ivl_val, 11999);
    chk(!ivl_tgl, "R1 ivl_tgl", ivl_tgl, 0);
  endtask

  task automatic t_idle();
    bit_stb = 1'b1;
    for (int i = 0; i < 5; i++) begin
      tick();
      chk(!sof && fnum == 0 && rem_word == 0, "R7 idle hold", rem_word, 0);
    end
    bit_stb = 1'b0;
  endtask

  task automatic t_first_frame();
    wr_ivl(14'd3, 1'b1);
    chk(ivl_val == 3 && ivl_tgl, "R8 stored interval", ivl_val, 3);
    chk(rem_word == 0, "R8 count untouched", rem_word, 0);
    run = 1'b1;
    tick();
    chk(rem_word == 32'h8000_0003, "R6 R5 R2 entry load", rem_word, 32'h8000_0003);
    chk(!sof && fnum == 0, "R6 no sof on entry", fnum, 0);
    bit_stb = 1'b1;
    for (int i = 2; i >= 0; i--) begin
      tick();
      chk(rem_word[13:0] == i[13:0] && !sof, "R3 decrement", rem_word[13:0], i);
    end
    tick();
    chk(rem_word == 32'h8000_0003, "R4 reload", rem_word, 32'h8000_0003);
    chk(fnum == 1 && sof, "R4 fnum and sof", fnum, 1);
    bit_stb = 1'b0;
    tick();
    chk(!sof, "R4 sof one cycle", sof, 0);
    chk(rem_word[13:0] == 3, "R3 no strobe hold", rem_word[13:0], 3);
  endtask

  task automatic t_mid_write();
    bit_stb = 1'b1;
    tick();
    bit_stb = 1'b0;
    wr_ivl(14'd5, 1'b0);
    chk(rem_word == 32'h8000_0002, "R8 write leaves count", rem_word, 32'h8000_0002);
    bit_stb = 1'b1;
    tick(); tick();
    chk(rem_word == 32'h8000_0000, "R3 to zero", rem_word, 32'h8000_0000);
    tick();
    chk(rem_word == 32'h0000_0005, "R8 R5 new interval at reload", rem_word, 5);
    chk(fnum == 2 && sof, "R4 second frame", fnum, 2);
  endtask

  task automatic t_reentry();
    tick();
    chk(rem_word[13:0] == 4, "R3 count", rem_word[13:0], 4);
    bit_stb = 1'b0;
    run = 1'b0;
    bit_stb = 1'b1;
    for (int i = 0; i < 3; i++) begin
      tick();
      chk(rem_word[13:0] == 4 && !sof && fnum == 2, "R7 hold", rem_word[13:0], 4);
    end
    bit_stb = 1'b0;
    wr_ivl(14'd2, 1'b1);
    run = 1'b1; bit_stb = 1'b1;
    tick();
    chk(rem_word == 32'h8000_0002, "R6 immediate reload", rem_word, 32'h8000_0002);
    chk(fnum == 2 && !sof, "R6 fnum unchanged", fnum, 2);
  endtask

  task automatic t_wrap();
    int nsof = 0;
    bit_stb = 1'b0;
    wr_ivl(14'd0, 1'b0);
    bit_stb = 1'b1;
    tick(); tick(); tick();
    chk(fnum == 3 && sof && rem_word == 0, "R4 reload to zero interval", fnum, 3);
    for (int i = 0; i < 65533; i++) begin
      tick();
      if (sof) nsof++;
    end
    chk(nsof == 65533, "R4 sof every strobe", nsof, 65533);
    chk(fnum == 0, "R9 wrap", fnum, 0);
    tick();
    chk(fnum == 1, "R9 after wrap", fnum, 1);
    bit_stb = 1'b0;
  endtask

  task automatic t_default_frame();
    int n = 0;
    run = 1'b0;
    rst_n = 1'b0;
    tick();
    rst_n = 1'b1;
    tick();
    run = 1'b1;
    tick();
    chk(rem_word == 11999, "R10 entry default", rem_word, 11999);
    bit_stb = 1'b1;
    while (n < 13000) begin
      tick();
      n++;
      if (sof) break;
    end
    chk(n == 12000, "R10 frame length", n, 12000);
    chk(fnum == 1, "R10 fnum", fnum, 1);
    bit_stb = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #1;
    tick(); tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_idle();
    t_first_frame();
    t_mid_write();
    t_reentry();
    t_wrap();
    t_default_frame();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule